// File: doc/BRIEF.md
# 100BASE-X Transmit 4B/5B Symbol Encoder

This block sits in the transmit path of a 100 Mb/s physical layer. It runs at the 25 MHz symbol rate. On every clock it takes the MII transmit signals (enable, error and a data nibble) and turns them into one registered 5-bit code group. That code group goes to a downstream serializer and scrambler.

Between frames the block sends a steady stream of idle code groups. When a frame starts, the first preamble byte is swapped for the start-of-stream pair: J first, then K. The nibbles that follow are mapped through the 4B/5B data table. A nibble that arrives with the error input high is sent as the halt code group instead of its data code. When the enable input falls, the end-of-stream pair (T, then R) is appended before the block returns to idle.

A bypass select turns all coding and framing off. In bypass, the error bit and the nibble together are sent out unchanged as a raw 5-bit value.

Top module: `tx_sym_enc`

## Requirements
- R1: While `rst` is high, and on the first clock edge with `rst` high, `sym_out` becomes the idle code 11111 and the framing state returns to idle.
- R2: Every output follows the inputs sampled at one rising edge, and is visible immediately after that edge. The latency is one clock.
- R3: With `bypass` low and no frame in progress, each edge that samples `tx_en` low produces idle (11111).
- R4: An edge that samples `tx_en` high while idle produces J (11000). The next edge produces K (10001). The two nibbles sampled at those edges are discarded.
- R5: After K, each edge that samples `tx_en` high and `tx_er` low outputs the data code for `txd`. The codes for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R6: After K, an edge that samples both `tx_en` and `tx_er` high outputs HALT (00100) in place of the data code.
- R7: After K, the first edge that samples `tx_en` low outputs T (01101). The next edge outputs R (00111). After R, the block is idle again, and an edge that samples `tx_en` high starts a new frame with J.
- R8: If `tx_en` is low at the edge that would emit K, K is still emitted, followed by T and R.
- R9: An edge that samples `bypass` high outputs {`tx_er`,`txd`} unchanged and abandons any frame in progress. The first edge after `bypass` falls behaves as idle: it outputs J if `tx_en` is high, and idle otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Raw 5-bit pass-through select |
| tx_en | input | 1 | Frame transmit enable |
| tx_er | input | 1 | Transmit error; bit 4 of the raw symbol in bypass |
| txd | input | 4 | Transmit data nibble |
| sym_out | output | 5 | Registered code group |

## Verification
Each code group is due exactly one rising edge after the inputs that cause it are sampled, with no dependence on earlier output. The single exception is that T and R, and a forced K, are due on the edges that follow the falling enable. The bench changes inputs on falling edges and compares `sym_out` at the next falling edge, so every check sits one full edge after its stimulus. Multi-symbol sequences (J/K, T/R, an early enable drop, leaving bypass) are checked symbol by symbol, on consecutive falling edges.

// File: rtl/tx_sym_pkg.sv
package tx_sym_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = NIB_W + 1;

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_HALT = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K    = 3'd1,
    ST_DATA = 3'd2,
    ST_T    = 3'd3,
    ST_R    = 3'd4
  } enc_state_t;

  typedef enum logic [2:0] {
    SEL_IDLE = 3'd0,
    SEL_J    = 3'd1,
    SEL_K    = 3'd2,
    SEL_DATA = 3'd3,
    SEL_HALT = 3'd4,
    SEL_T    = 3'd5,
    SEL_R    = 3'd6,
    SEL_RAW  = 3'd7
  } sym_sel_t;
endpackage

// File: rtl/tx_sym_codebook.sv
module tx_sym_codebook
  import tx_sym_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output logic [SYM_W-1:0] code
);
  always_comb begin
    unique case (nib)
      4'h0: code = 5'b11110;
      4'h1: code = 5'b01001;
      4'h2: code = 5'b10100;
      4'h3: code = 5'b10101;
      4'h4: code = 5'b01010;
      4'h5: code = 5'b01011;
      4'h6: code = 5'b01110;
      4'h7: code = 5'b01111;
      4'h8: code = 5'b10010;
      4'h9: code = 5'b10011;
      4'hA: code = 5'b10110;
      4'hB: code = 5'b10111;
      4'hC: code = 5'b11010;
      4'hD: code = 5'b11011;
      4'hE: code = 5'b11100;
      default: code = 5'b11101;
    endcase
  end
endmodule

// File: rtl/tx_sym_ctrl.sv
module tx_sym_ctrl
  import tx_sym_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bypass,
  input  logic       tx_en,
  input  logic       tx_er,
  output enc_state_t state,
  output sym_sel_t   sel
);
  enc_state_t state_nx;

  always_comb begin
    state_nx = state;
    sel      = SEL_IDLE;
    if (bypass) begin
      state_nx = ST_IDLE;
      sel      = SEL_RAW;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (tx_en) begin
            sel      = SEL_J;
            state_nx = ST_K;
          end
        end
        ST_K: begin
          sel      = SEL_K;
          state_nx = tx_en ? ST_DATA : ST_T;
        end
        ST_DATA: begin
          if (tx_en) begin
            sel = tx_er ? SEL_HALT : SEL_DATA;
          end else begin
            sel      = SEL_T;
            state_nx = ST_R;
          end
        end
        ST_T: begin
          sel      = SEL_T;
          state_nx = ST_R;
        end
        ST_R: begin
          sel      = SEL_R;
          state_nx = ST_IDLE;
        end
        default: begin
          sel      = SEL_IDLE;
          state_nx = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end
endmodule

// File: rtl/tx_sym_outreg.sv
module tx_sym_outreg
  import tx_sym_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  sym_sel_t         sel,
  input  logic [SYM_W-1:0] data_code,
  input  logic [SYM_W-1:0] raw_sym,
  output logic [SYM_W-1:0] sym_q
);
  logic [SYM_W-1:0] sym_d;

  always_comb begin
    unique case (sel)
      SEL_J:    sym_d = CG_J;
      SEL_K:    sym_d = CG_K;
      SEL_DATA: sym_d = data_code;
      SEL_HALT: sym_d = CG_HALT;
      SEL_T:    sym_d = CG_T;
      SEL_R:    sym_d = CG_R;
      SEL_RAW:  sym_d = raw_sym;
      default:  sym_d = CG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sym_q <= CG_IDLE;
    else     sym_q <= sym_d;
  end
endmodule

// File: rtl/tx_sym_enc.sv
module tx_sym_enc
  import tx_sym_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output logic [SYM_W-1:0] sym_out
);
  enc_state_t       state;
  sym_sel_t         sel;
  logic [SYM_W-1:0] data_code;

  tx_sym_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .bypass (bypass),
    .tx_en  (tx_en),
    .tx_er  (tx_er),
    .state  (state),
    .sel    (sel)
  );

  tx_sym_codebook u_book (
    .nib  (txd),
    .code (data_code)
  );

  tx_sym_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .data_code (data_code),
    .raw_sym   ({tx_er, txd}),
    .sym_q     (sym_out)
  );
endmodule

// File: rtl/tx_sym_enc_chk.sv
module tx_sym_enc_chk
  import tx_sym_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bypass,
  input logic             tx_en,
  input logic             tx_er,
  input logic [NIB_W-1:0] txd,
  input logic [SYM_W-1:0] sym_out,
  input enc_state_t       state
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (sym_out == CG_IDLE && state == ST_IDLE));

  assert_idle_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (!bypass && state == ST_IDLE && !tx_en) |=> sym_out == CG_IDLE);

  assert_j_before_k_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_K) |-> sym_out == CG_J);

  assert_halt_sub_R6: assert property (@(posedge clk) disable iff (rst)
    (!bypass && state == ST_DATA && tx_en && tx_er) |=> sym_out == CG_HALT);

  assert_t_before_r_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_R) |-> sym_out == CG_T);

  assert_r_after_t_R7: assert property (@(posedge clk) disable iff (rst)
    (!bypass && state == ST_R) |=> sym_out == CG_R);

  assert_k_forced_R8: assert property (@(posedge clk) disable iff (rst)
    (!bypass && state == ST_K && !tx_en) |=> (sym_out == CG_K && state == ST_T));

  assert_raw_pass_R9: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (sym_out == $past({tx_er, txd}) && state == ST_IDLE));
endmodule

bind tx_sym_enc tx_sym_enc_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .bypass  (bypass),
  .tx_en   (tx_en),
  .tx_er   (tx_er),
  .txd     (txd),
  .sym_out (sym_out),
  .state   (state)
);

// File: tb/tx_sym_enc_test.sv
`timescale 1ns/1ps
module tx_sym_enc_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bypass = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [4:0] sym_out;

  int checks = 0;
  int errors = 0;

  localparam logic [4:0] E_IDLE = 5'b11111;
  localparam logic [4:0] E_J    = 5'b11000;
  localparam logic [4:0] E_K    = 5'b10001;
  localparam logic [4:0] E_T    = 5'b01101;
  localparam logic [4:0] E_R    = 5'b00111;
  localparam logic [4:0] E_HALT = 5'b00100;

  logic [4:0] dcode [16];
  initial begin
    dcode = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
              5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
              5'b11010, 5'b11011, 5'b11100, 5'b11101};
  end

  always #4 clk = ~clk;

  tx_sym_enc uut (
    .clk(clk), .rst(rst), .bypass(bypass), .tx_en(tx_en),
    .tx_er(tx_er), .txd(txd), .sym_out(sym_out)
  );

  task automatic check(input logic [4:0] exp, input string tag);
    checks++;
    if (sym_out !== exp) begin
      errors++;
      $display("FAIL %s: sym_out=%b expected=%b at %0t", tag, sym_out, exp, $time);
    end
  endtask

  // Called at a falling edge: drive inputs, wait one edge, check result.
  task automatic cyc(input logic byp, input logic en, input logic er,
                     input logic [3:0] d, input logic [4:0] exp, input string tag);
    bypass = byp; tx_en = en; tx_er = er; txd = d;
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic test_reset;
    rst = 1'b1; tx_en = 1'b1; txd = 4'h5;
    @(negedge clk);
    check(E_IDLE, "R1 reset output");
    @(negedge clk);
    check(E_IDLE, "R1 reset held with tx_en");
    rst = 1'b0;
    cyc(0, 0, 0, 4'h0, E_IDLE, "R1 first edge after reset");
  endtask

  task automatic test_idle;
    cyc(0, 0, 0, 4'h3, E_IDLE, "R3 idle gap a");
    cyc(0, 0, 1, 4'hA, E_IDLE, "R3 idle gap with tx_er");
    cyc(0, 0, 0, 4'hF, E_IDLE, "R3 idle gap c");
  endtask

  task automatic test_full_frame;
    cyc(0, 1, 0, 4'h5, E_J, "R4 J at start, R2 one-cycle latency");
    cyc(0, 1, 0, 4'h5, E_K, "R4 K second");
    for (int i = 0; i < 16; i++) cyc(0, 1, 0, 4'(i), dcode[i], "R5 data code");
    cyc(0, 1, 0, 4'hD, dcode[13], "R5 preamble-like nibble coded");
    cyc(0, 0, 0, 4'h0, E_T, "R7 T after enable drop");
    cyc(0, 0, 0, 4'h0, E_R, "R7 R after T");
    cyc(0, 0, 0, 4'h0, E_IDLE, "R3 idle after R");
  endtask

  task automatic test_halt;
    cyc(0, 1, 1, 4'h5, E_J, "R6 tx_er during J ignored");
    cyc(0, 1, 0, 4'h5, E_K, "R6 K");
    cyc(0, 1, 0, 4'h2, dcode[2], "R6 data before error");
    cyc(0, 1, 1, 4'h2, E_HALT, "R6 halt substitution");
    cyc(0, 1, 1, 4'h9, E_HALT, "R6 halt repeated");
    cyc(0, 1, 0, 4'h9, dcode[9], "R6 data after error");
    cyc(0, 0, 1, 4'h0, E_T, "R7 T with tx_er high");
    cyc(0, 0, 0, 4'h0, E_R, "R7 R");
  endtask

  task automatic test_back_to_back;
    cyc(0, 1, 0, 4'h5, E_J, "R7 J");
    cyc(0, 1, 0, 4'h5, E_K, "R7 K");
    cyc(0, 1, 0, 4'h7, dcode[7], "R7 data");
    cyc(0, 0, 0, 4'h0, E_T, "R7 T");
    cyc(0, 1, 0, 4'h5, E_R, "R7 R despite tx_en");
    cyc(0, 1, 0, 4'h5, E_J, "R7 new frame J right after R");
    cyc(0, 1, 0, 4'h5, E_K, "R7 new frame K");
    cyc(0, 0, 0, 4'h0, E_T, "R7 T new frame");
    cyc(0, 0, 0, 4'h0, E_R, "R7 R new frame");
    cyc(0, 0, 0, 4'h0, E_IDLE, "R3 idle");
  endtask

  task automatic test_early_drop;
    cyc(0, 1, 0, 4'h5, E_J, "R8 J");
    cyc(0, 0, 0, 4'h0, E_K, "R8 K forced");
    cyc(0, 0, 0, 4'h0, E_T, "R8 T");
    cyc(0, 0, 0, 4'h0, E_R, "R8 R");
    cyc(0, 0, 0, 4'h0, E_IDLE, "R8 idle");
    cyc(0, 1, 0, 4'h5, E_J, "R8 J second");
    cyc(0, 1, 0, 4'h5, E_K, "R8 K second");
    cyc(0, 0, 0, 4'h0, E_T, "R8 T right after K");
    cyc(0, 0, 0, 4'h0, E_R, "R8 R right after T");
  endtask

  task automatic test_bypass;
    cyc(1, 0, 0, 4'h0, 5'b00000, "R9 raw 00000");
    cyc(1, 1, 1, 4'hF, 5'b11111, "R9 raw 11111");
    cyc(1, 1, 0, 4'hA, 5'b01010, "R9 raw 01010");
    cyc(1, 0, 1, 4'h3, 5'b10011, "R9 raw 10011");
    cyc(1, 1, 1, 4'h8, 5'b11000, "R9 raw J-valued");
    cyc(0, 0, 0, 4'h0, E_IDLE, "R9 idle after bypass");
    cyc(0, 1, 0, 4'h5, E_J, "R9 J");
    cyc(0, 1, 0, 4'h5, E_K, "R9 K");
    cyc(0, 1, 0, 4'h4, dcode[4], "R9 data");
    cyc(1, 1, 0, 4'h4, 5'b00100, "R9 bypass mid-frame raw");
    cyc(0, 1, 0, 4'h6, E_J, "R9 frame abandoned, restart J");
    cyc(0, 1, 0, 4'h5, E_K, "R9 K after restart");
    cyc(0, 0, 0, 4'h0, E_T, "R9 T");
    cyc(0, 0, 0, 4'h0, E_R, "R9 R");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_idle();
    test_full_frame();
    test_halt();
    test_back_to_back();
    test_early_drop();
    test_bypass();
    rst = 1'b1;
    @(negedge clk);
    check(E_IDLE, "R1 reset mid-run");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule